// File: doc/BRIEF.md
# Omega Multistage Interconnect Router

This block moves single-word packets from N source ports to N destination ports through a shuffle-exchange fabric. There are log2(N) stages of 2x2 switches. Ahead of every stage the lanes are rewired by a perfect shuffle. Each switch then sends each of its two packets to its upper or its lower output, one address bit per stage. Source ports present packets together in one cycle. Each packet has a valid flag, a destination index and a payload. One clock later the delivered packets appear on the output port named by their destination index, together with the index of the port they came from.

The fabric is blocking. When two packets at one switch ask for the same output, the packet on the upper input keeps its path and the other packet is discarded. The block reports the discarded packet by its source index, and it reports which stages saw a conflict. A mode input chooses how each switch forms its decision. In destination-tag mode the switch uses the destination bit alone. In XOR-tag mode it uses the XOR of the source and destination bits, applied as a cross or no-cross setting. Both modes deliver a packet to the same port.

Top module: `omega_router`

## Requirements
- R1: A valid packet that meets no conflict appears on out_vld/out_data/out_src at the port equal to its destination, on the first clock edge after it is sampled. Its payload is unchanged, and out_src holds the index of the input port it entered on.
- R2: With route_mode = 0 (destination-tag), the switch in stage k (stage 0 nearest the inputs) sends a packet to its upper output when destination bit (log2(N)-1-k) is 0, and to its lower output when that bit is 1.
- R3: With route_mode = 1 (XOR-tag), the switch in stage k crosses a packet when bit (log2(N)-1-k) of (source XOR destination) is 1 and passes it straight when the bit is 0. Every packet reaches the same port as in R2.
- R4: Before each stage, lane i feeds lane rotl(i), which is a one-bit left rotation of the log2(N)-bit index. Switch e takes lane 2e as its upper input and lane 2e+1 as its lower input, so sources 0 and N/2 meet at switch 0 of stage 0.
- R5: When two valid packets at one switch request the same output, the upper-input packet proceeds and the lower one is discarded. In the same output cycle, bit s of drop_vec is 1, where s is the discarded packet's source index.
- R6: Bit k of stage_hit is 1 in an output cycle exactly when at least one packet was discarded in stage k.
- R7: An input whose valid bit is 0 produces no output. Every port that receives no packet shows out_vld 0.
- R8: While rst_n is low, out_vld, drop_vec and stage_hit are all 0.
- R9: Each valid input packet is counted exactly once in each output cycle, either as one out_vld bit or as one drop_vec bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| route_mode | input | 1 | 0 = destination-tag, 1 = XOR-tag |
| in_vld | input | N_PORTS | Per-source packet valid |
| in_dst | input | N_PORTS*ADDR_W | Per-source destination index, source i in bits [i*ADDR_W +: ADDR_W] |
| in_data | input | N_PORTS*DATA_W | Per-source payload, source i in bits [i*DATA_W +: DATA_W] |
| out_vld | output | N_PORTS | Per-destination packet delivered |
| out_src | output | N_PORTS*ADDR_W | Source index of the packet at each destination |
| out_data | output | N_PORTS*DATA_W | Payload at each destination |
| drop_vec | output | N_PORTS | Bit s set when the packet from source s was discarded |
| stage_hit | output | ADDR_W | Bit k set when stage k discarded a packet |

## Verification
The bench targets the meeting of sources 0 and N/2 at the first switch. A design with the shuffle rotated the wrong way, or with the lanes paired wrongly, would either deliver both packets or drop the wrong one. Sending every source to destination 0 stacks conflicts in every stage. A priority swapped to the lower input would show a different surviving source, and a design that lost track of stage indices would light the wrong stage_hit bits. The identity and bit-reversal permutations, run in both modes, catch a reversed address-bit order or a broken XOR cross decision, because those errors misdeliver payloads. Random traffic is compared on every cycle against a lane-by-lane reference model.

// File: rtl/omega_pkg.sv
package omega_pkg;

   typedef enum logic {
      ROUTE_DEST = 1'b0,
      ROUTE_XOR  = 1'b1
   } route_mode_e;

   // Perfect shuffle: one-bit left rotation of a lane index of 'bits' bits.
   function automatic int unsigned shuffle_idx(input int unsigned idx,
                                                input int unsigned bits);
      int unsigned mask;
      mask = (32'd1 << bits) - 32'd1;
      return ((idx << 1) | (idx >> (bits - 1))) & mask;
   endfunction

endpackage

// File: rtl/omega_switch_elem.sv
module omega_switch_elem
   import omega_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 16,
   parameter int BITPOS = 2
) (
   input  route_mode_e                   mode,
   input  logic [1:0]                    in_vld,
   input  logic [1:0][ADDR_W-1:0]        in_src,
   input  logic [1:0][ADDR_W-1:0]        in_dst,
   input  logic [1:0][DATA_W-1:0]        in_data,
   output logic [1:0]                    out_vld,
   output logic [1:0][ADDR_W-1:0]        out_src,
   output logic [1:0][ADDR_W-1:0]        out_dst,
   output logic [1:0][DATA_W-1:0]        out_data,
   output logic                          lose
);

   logic [1:0] tag;
   logic [1:0] req;

   // Output request per input: destination bit, or cross/straight from
   // the XOR tag relative to the input's own position.
   generate
      for (genvar i = 0; i < 2; i++) begin : g_req
         if (BITPOS < ADDR_W) begin : g_ok
            always_comb begin
               if (mode == ROUTE_XOR) begin
                  tag[i] = in_dst[i][BITPOS] ^ in_src[i][BITPOS];
                  req[i] = tag[i] ^ 1'(i);
               end else begin
                  tag[i] = in_dst[i][BITPOS];
                  req[i] = tag[i];
               end
            end
         end
      end
   endgenerate

   assign lose = in_vld[0] & in_vld[1] & (req[0] == req[1]);

   // Upper input has priority on every output.
   always_comb begin
      for (int o = 0; o < 2; o++) begin
         out_vld[o]  = 1'b0;
         out_src[o]  = '0;
         out_dst[o]  = '0;
         out_data[o] = '0;
         if (in_vld[0] && (req[0] == 1'(o))) begin
            out_vld[o]  = 1'b1;
            out_src[o]  = in_src[0];
            out_dst[o]  = in_dst[0];
            out_data[o] = in_data[0];
         end else if (in_vld[1] && (req[1] == 1'(o))) begin
            out_vld[o]  = 1'b1;
            out_src[o]  = in_src[1];
            out_dst[o]  = in_dst[1];
            out_data[o] = in_data[1];
         end
      end
   end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
   import omega_pkg::*;
#(
   parameter int N_PORTS = 8,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 16,
   parameter int STAGE   = 0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  route_mode_e                        mode,
   input  logic [N_PORTS-1:0]                 in_vld,
   input  logic [N_PORTS-1:0][ADDR_W-1:0]     in_src,
   input  logic [N_PORTS-1:0][ADDR_W-1:0]     in_dst,
   input  logic [N_PORTS-1:0][DATA_W-1:0]     in_data,
   output logic [N_PORTS-1:0]                 out_vld,
   output logic [N_PORTS-1:0][ADDR_W-1:0]     out_src,
   output logic [N_PORTS-1:0][ADDR_W-1:0]     out_dst,
   output logic [N_PORTS-1:0][DATA_W-1:0]     out_data,
   output logic [N_PORTS-1:0]                 drop_mask,
   output logic                               hit
);

   localparam int N_ELEM = N_PORTS / 2;
   localparam int BITPOS = ADDR_W - 1 - STAGE;

   logic [N_PORTS-1:0]               sh_vld;
   logic [N_PORTS-1:0][ADDR_W-1:0]   sh_src;
   logic [N_PORTS-1:0][ADDR_W-1:0]   sh_dst;
   logic [N_PORTS-1:0][DATA_W-1:0]   sh_data;
   logic [N_ELEM-1:0]                lose;

   // Perfect-shuffle wiring ahead of the switch column.
   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_shuf
         localparam int Q = int'(shuffle_idx(p, ADDR_W));
         assign sh_vld[Q]  = in_vld[p];
         assign sh_src[Q]  = in_src[p];
         assign sh_dst[Q]  = in_dst[p];
         assign sh_data[Q] = in_data[p];
      end

      for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
         omega_switch_elem #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .BITPOS (BITPOS)
         ) u_sw (
            .mode     (mode),
            .in_vld   (sh_vld[2*e +: 2]),
            .in_src   (sh_src[2*e +: 2]),
            .in_dst   (sh_dst[2*e +: 2]),
            .in_data  (sh_data[2*e +: 2]),
            .out_vld  (out_vld[2*e +: 2]),
            .out_src  (out_src[2*e +: 2]),
            .out_dst  (out_dst[2*e +: 2]),
            .out_data (out_data[2*e +: 2]),
            .lose     (lose[e])
         );
      end
   endgenerate

   // Discarded packet is always the lower input; flag it by source index.
   always_comb begin
      drop_mask = '0;
      for (int e = 0; e < N_ELEM; e++) begin
         if (lose[e]) drop_mask[sh_src[2*e+1]] = 1'b1;
      end
   end

   assign hit = |lose;

   // R9: a stage neither creates nor silently loses packets.
   p_stage_conserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(out_vld) + $countones(drop_mask)) == $countones(in_vld));

   // R5: a discarded packet must have entered this stage valid.
   p_drop_from_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((drop_mask & ~in_vld_by_src(in_vld, in_src)) == '0));

   function automatic logic [N_PORTS-1:0] in_vld_by_src(
      input logic [N_PORTS-1:0]             v,
      input logic [N_PORTS-1:0][ADDR_W-1:0] s);
      logic [N_PORTS-1:0] m;
      m = '0;
      for (int i = 0; i < N_PORTS; i++) if (v[i]) m[s[i]] = 1'b1;
      return m;
   endfunction

endmodule

// File: rtl/omega_router.sv
module omega_router
   import omega_pkg::*;
#(
   parameter int N_PORTS = 8,
   parameter int DATA_W  = 16,
   localparam int ADDR_W = $clog2(N_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        route_mode,
   input  logic [N_PORTS-1:0]          in_vld,
   input  logic [N_PORTS*ADDR_W-1:0]   in_dst,
   input  logic [N_PORTS*DATA_W-1:0]   in_data,
   output logic [N_PORTS-1:0]          out_vld,
   output logic [N_PORTS*ADDR_W-1:0]   out_src,
   output logic [N_PORTS*DATA_W-1:0]   out_data,
   output logic [N_PORTS-1:0]          drop_vec,
   output logic [ADDR_W-1:0]           stage_hit
);

   localparam int N_STAGE = ADDR_W;

   generate
      if (N_PORTS < 4 || N_PORTS > 16 || (N_PORTS & (N_PORTS - 1)) != 0) begin : g_bad_ports
         $error("omega_router: N_PORTS must be a power of two in 4..16");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("omega_router: DATA_W must be at least 1");
      end
   endgenerate

   route_mode_e mode;
   assign mode = route_mode_e'(route_mode);

   logic [N_STAGE:0][N_PORTS-1:0]               ln_vld;
   logic [N_STAGE:0][N_PORTS-1:0][ADDR_W-1:0]   ln_src;
   logic [N_STAGE:0][N_PORTS-1:0][ADDR_W-1:0]   ln_dst;
   logic [N_STAGE:0][N_PORTS-1:0][DATA_W-1:0]   ln_data;
   logic [N_STAGE-1:0][N_PORTS-1:0]             st_drop;
   logic [N_STAGE-1:0]                          st_hit;
   logic [N_PORTS-1:0]                          drop_all;

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_entry
         assign ln_vld[0][p]  = in_vld[p];
         assign ln_src[0][p]  = ADDR_W'(p);
         assign ln_dst[0][p]  = in_dst[p*ADDR_W +: ADDR_W];
         assign ln_data[0][p] = in_data[p*DATA_W +: DATA_W];
      end

      for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
         omega_stage #(
            .N_PORTS (N_PORTS),
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .STAGE   (k)
         ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .in_vld    (ln_vld[k]),
            .in_src    (ln_src[k]),
            .in_dst    (ln_dst[k]),
            .in_data   (ln_data[k]),
            .out_vld   (ln_vld[k+1]),
            .out_src   (ln_src[k+1]),
            .out_dst   (ln_dst[k+1]),
            .out_data  (ln_data[k+1]),
            .drop_mask (st_drop[k]),
            .hit       (st_hit[k])
         );
      end
   endgenerate

   always_comb begin
      drop_all = '0;
      for (int k = 0; k < N_STAGE; k++) drop_all = drop_all | st_drop[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= '0;
         out_src   <= '0;
         out_data  <= '0;
         drop_vec  <= '0;
         stage_hit <= '0;
      end else begin
         out_vld   <= ln_vld[N_STAGE];
         out_src   <= ln_src[N_STAGE];
         out_data  <= ln_data[N_STAGE];
         drop_vec  <= drop_all;
         stage_hit <= st_hit;
      end
   end

   // Marks that at least one capture edge has followed reset release.
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   // R8: outputs held clear during reset.
   p_reset_clear_r8: assert property (@(posedge clk)
      !rst_n |-> (out_vld == '0 && drop_vec == '0 && stage_hit == '0));

   // R9: every valid input is delivered or dropped, once.
   p_conserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (($countones(out_vld) + $countones(drop_vec)) == $countones($past(in_vld))));

   // R6: stage flags and dropped-source flags appear together.
   p_hit_pairs_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_hit != '0) == (drop_vec != '0));

   generate
      for (genvar j = 0; j < N_PORTS; j++) begin : g_chk
         // R1: fabric lane j only ever carries destination j.
         p_lane_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ln_vld[N_STAGE][j] |-> (ln_dst[N_STAGE][j] == ADDR_W'(j)));

         // R1: delivered packet came from a valid input one cycle earlier,
         // addressed to this port, with its payload intact.
         p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && out_vld[j]) |->
               ((1'($past(in_vld) >> out_src[j*ADDR_W +: ADDR_W]) == 1'b1) &&
                (ADDR_W'($past(in_dst) >> (out_src[j*ADDR_W +: ADDR_W] * ADDR_W)) == ADDR_W'(j)) &&
                (DATA_W'($past(in_data) >> (out_src[j*ADDR_W +: ADDR_W] * DATA_W)) ==
                 out_data[j*DATA_W +: DATA_W])));

         // R5: a dropped source was valid on the sampled cycle.
         p_drop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && drop_vec[j]) |-> $past(in_vld[j]));
      end
   endgenerate

endmodule

// File: tb/omega_router_test.sv
module omega_router_test;

   localparam int N = 8;
   localparam int A = 3;
   localparam int D = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b1;
   logic           route_mode = 1'b0;
   logic [N-1:0]   in_vld = '0;
   logic [N*A-1:0] in_dst = '0;
   logic [N*D-1:0] in_data = '0;
   logic [N-1:0]   out_vld;
   logic [N*A-1:0] out_src;
   logic [N*D-1:0] out_data;
   logic [N-1:0]   drop_vec;
   logic [A-1:0]   stage_hit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int          b_vld [N];
   int          b_dst [N];
   logic [D-1:0] b_data [N];

   int          e_vld [N];
   int          e_src [N];
   logic [N-1:0] e_drop;
   logic [A-1:0] e_hit;

   always #10 clk = ~clk;

   omega_router #(.N_PORTS(N), .DATA_W(D)) uut (
      .clk(clk), .rst_n(rst_n), .route_mode(route_mode),
      .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
      .out_vld(out_vld), .out_src(out_src), .out_data(out_data),
      .drop_vec(drop_vec), .stage_hit(stage_hit)
   );

   function automatic int rotl(input int p);
      return ((p << 1) | (p >> (A - 1))) & (N - 1);
   endfunction

   // Reference: walk each packet lane by lane, upper input wins ties.
   task automatic model();
      int lane [N];
      int sh [N];
      for (int i = 0; i < N; i++) lane[i] = b_vld[i] ? i : -1;
      e_drop = '0;
      e_hit  = '0;
      for (int k = 0; k < A; k++) begin
         for (int p = 0; p < N; p++) sh[rotl(p)] = lane[p];
         for (int p = 0; p < N; p++) lane[p] = -1;
         for (int e = 0; e < N / 2; e++) begin
            int u = sh[2*e];
            int l = sh[2*e+1];
            int bu = (u >= 0) ? ((b_dst[u] >> (A - 1 - k)) & 1) : 0;
            int bl = (l >= 0) ? ((b_dst[l] >> (A - 1 - k)) & 1) : 0;
            if (u >= 0) lane[2*e + bu] = u;
            if (l >= 0) begin
               if (u >= 0 && bu == bl) begin
                  e_drop[l] = 1'b1;
                  e_hit[k]  = 1'b1;
               end else begin
                  lane[2*e + bl] = l;
               end
            end
         end
      end
      for (int j = 0; j < N; j++) begin
         e_vld[j] = (lane[j] >= 0);
         e_src[j] = lane[j];
      end
   endtask

   task automatic fail_msg(input string req, input string what,
                           input longint act, input longint exp);
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   // Drive at a falling edge, check at the next falling edge.
   task automatic step(input int mode);
      string tag;
      int nv;
      route_mode = 1'(mode);
      for (int i = 0; i < N; i++) begin
         in_vld[i]         = 1'(b_vld[i]);
         in_dst[i*A +: A]  = A'(b_dst[i]);
         in_data[i*D +: D] = b_data[i];
      end
      model();
      tag = (mode != 0) ? "R3" : "R2";
      @(negedge clk);
      for (int j = 0; j < N; j++) begin
         checks++;
         if (out_vld[j] !== 1'(e_vld[j]))
            fail_msg(e_vld[j] ? tag : "R7", $sformatf("out_vld[%0d]", j), out_vld[j], e_vld[j]);
         else if (e_vld[j] != 0) begin
            if (out_src[j*A +: A] !== A'(e_src[j]))
               fail_msg("R1", $sformatf("out_src[%0d]", j), out_src[j*A +: A], e_src[j]);
            else if (out_data[j*D +: D] !== b_data[e_src[j]])
               fail_msg("R1", $sformatf("out_data[%0d]", j), out_data[j*D +: D], b_data[e_src[j]]);
         end
      end
      checks++;
      if (drop_vec !== e_drop) fail_msg("R5", "drop_vec", drop_vec, e_drop);
      checks++;
      if (stage_hit !== e_hit) fail_msg("R6", "stage_hit", stage_hit, e_hit);
      nv = 0;
      for (int i = 0; i < N; i++) nv += b_vld[i];
      checks++;
      if ($countones(out_vld) + $countones(drop_vec) != nv)
         fail_msg("R9", "delivered+dropped", $countones(out_vld) + $countones(drop_vec), nv);
   endtask

   task automatic fill(input int kind);
      for (int i = 0; i < N; i++) begin
         b_vld[i]  = 1;
         b_data[i] = D'(16'hA500 + i * 16'h0111);
         case (kind)
            0: b_dst[i] = i;
            1: b_dst[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
            default: b_dst[i] = 0;
         endcase
      end
   endtask

   initial begin
      #1 rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R8: reset state
      checks++;
      if (out_vld !== '0 || drop_vec !== '0 || stage_hit !== '0)
         fail_msg("R8", "outputs in reset", {out_vld, drop_vec}, 0);
      rst_n = 1'b1;

      // R1/R2/R3: identity permutation in both modes.
      fill(0); step(0);
      fill(0); step(1);
      // R1/R2/R3: bit-reversal permutation in both modes.
      fill(1); step(0);
      fill(1); step(1);

      // R4/R5/R6: sources 0 and N/2 meet at switch 0 of stage 0.
      for (int i = 0; i < N; i++) begin b_vld[i] = 0; b_dst[i] = 0; b_data[i] = D'(i); end
      b_vld[0] = 1; b_dst[0] = 0; b_data[0] = 16'h1111;
      b_vld[N/2] = 1; b_dst[N/2] = 1; b_data[N/2] = 16'h2222;
      step(0);
      checks++;
      if (drop_vec !== (N'(1) << (N/2))) fail_msg("R4", "pair drop_vec", drop_vec, N'(1) << (N/2));
      checks++;
      if (stage_hit !== A'(1)) fail_msg("R6", "pair stage_hit", stage_hit, 1);
      checks++;
      if (out_vld[0] !== 1'b1 || out_src[0 +: A] !== '0)
         fail_msg("R5", "upper winner at port 0", out_src[0 +: A], 0);
      step(1);

      // R5/R6: every source to port 0.
      fill(2); step(0);
      fill(2); step(1);

      // R7: nothing valid.
      for (int i = 0; i < N; i++) begin b_vld[i] = 0; b_dst[i] = i; end
      step(0);
      checks++;
      if (out_vld !== '0) fail_msg("R7", "idle out_vld", out_vld, 0);

      // R2/R3/R9: random traffic.
      for (int c = 0; c < 400; c++) begin
         for (int i = 0; i < N; i++) begin
            b_vld[i]  = int'($urandom_range(0, 3) != 0);
            b_dst[i]  = int'($urandom_range(0, N - 1));
            b_data[i] = D'($urandom);
         end
         step(int'($urandom_range(0, 1)));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

endmodule